// File: doc/BRIEF.md
# One-Hot Population Tally

This block counts how many bits of an N-bit input word are set and presents the answer as a one-hot vector with N+1 lines. Line k is high exactly when k input bits are 1. The tally is formed by a chain of identical one-bit routing stages. A one-hot token is injected at line 0 of the first stage. Each stage either passes the token to the same line or moves it up one line, depending on its own input bit. No line is ever left undriven: every line that does not carry the token is held at 0.

A registered wrapper captures the input word in any cycle where `in_valid` is high. The tally of the captured word then appears on the outputs from the next clock edge, with `out_valid` asserted for that one cycle. A binary form of the same count is also provided, derived from the one-hot vector, so that a consumer can compare the two.

Top module: `onehot_tally`

## Requirements
- R1: `tally_onehot` has N+1 bits, and bit k is 1 exactly when the captured word holds k ones. Bit 0 corresponds to a count of zero.
- R2: A captured word of all zeros yields `tally_onehot` equal to 1, meaning only bit 0 is set.
- R3: A captured word of all ones yields only bit N set.
- R4: `tally_count` is an unsigned binary value equal to the index of the set bit of `tally_onehot`.
- R5: `out_valid` is high in the cycle after a cycle in which `in_valid` was high at the clock edge, and low otherwise.
- R6: While `in_valid` is low, changes on `in_bits` have no effect: `tally_onehot` and `tally_count` keep the last captured result.
- R7: While `rst_n` is low, `out_valid` is 0, `tally_onehot` is 1 and `tally_count` is 0.
- R8: Exactly one bit of `tally_onehot` is 1 in every cycle. No line floats and no line is spuriously set.
- R9: The result depends only on the number of ones, not on their positions. Words with equal counts but different bit positions give identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for `in_bits` |
| in_bits | input | N | Word to be tallied |
| out_valid | output | 1 | Result of a fresh capture is present |
| tally_onehot | output | N+1 | One-hot count of set bits |
| tally_count | output | clog2(N+1) | Binary count of set bits |

## Verification
The bench drives the two extreme words, all zeros and all ones. A stage chain whose seed or top line is mis-wired would lose the token there or wrap it around. The bench applies several words that share a popcount but set different positions, which exposes a stage fed from the wrong input bit or routed the wrong way. It changes `in_bits` while `in_valid` is low; a wrapper that captures without its enable would show the new tally. It also checks `out_valid` across back-to-back captures and across gaps, which catches a valid flag that sticks high or arrives in the wrong cycle.

// File: rtl/tally_pkg.sv
package tally_pkg;

  // Width of a binary count that spans 0..n inclusive, never below one bit.
  function automatic int count_width(int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/tally_stage.sv
// One routing cell of the tally chain: straight when idle, diagonal when set.
module tally_stage #(
  parameter int LINES = 9
) (
  input  logic             take,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] line_out
);

  logic [LINES-1:0] straight;
  logic [LINES-1:0] diagonal;

  always_comb begin
    straight = line_in;
    // Line 0 receives a driven zero on the diagonal path.
    diagonal = {line_in[LINES-2:0], 1'b0};
    line_out = take ? diagonal : straight;
  end

endmodule

// File: rtl/tally_chain.sv
// Cascade of N routing cells, seeded with a token on line 0.
module tally_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0] bits,
  output logic [N:0]   onehot
);

  localparam int LINES = N + 1;

  logic [LINES-1:0] link [0:N];

  assign link[0] = LINES'(1);

  genvar s;
  generate
    for (s = 0; s < N; s++) begin : g_stage
      tally_stage #(.LINES(LINES)) u_stage (
        .take     (bits[s]),
        .line_in  (link[s]),
        .line_out (link[s+1])
      );
    end
  endgenerate

  assign onehot = link[N];

endmodule

// File: rtl/onehot_to_count.sv
// Encodes the one-hot tally into binary by OR-ing the indices of set lines.
module onehot_to_count #(
  parameter int N  = 8,
  parameter int CW = tally_pkg::count_width(N)
) (
  input  logic [N:0]    onehot,
  output logic [CW-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i <= N; i++) begin
      if (onehot[i]) count = count | CW'(i);
    end
  end

endmodule

// File: rtl/onehot_tally.sv
module onehot_tally #(
  parameter int N  = 8,
  parameter int CW = tally_pkg::count_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [N-1:0]  in_bits,
  output logic          out_valid,
  output logic [N:0]    tally_onehot,
  output logic [CW-1:0] tally_count
);

  logic [N-1:0] word_q, word_d;
  logic         vld_q, vld_d;

  // Next-state logic: capture only on enable.
  always_comb begin
    word_d = word_q;
    if (in_valid) word_d = in_bits;
    vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  tally_chain #(.N(N)) u_chain (
    .bits   (word_q),
    .onehot (tally_onehot)
  );

  onehot_to_count #(.N(N), .CW(CW)) u_enc (
    .onehot (tally_onehot),
    .count  (tally_count)
  );

  assign out_valid = vld_q;

  // R8: exactly one tally line high
  a_r8_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tally_onehot) == 1);

  // R4: binary count points at the set line
  a_r4_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    tally_onehot[tally_count] == 1'b1);

  // R5: valid follows a capture by one cycle
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R5: no valid without a capture
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6: tally frozen while no capture
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tally_onehot));

endmodule

// File: tb/onehot_tally_tb.sv
`timescale 1ns/1ps
module onehot_tally_tb;

  localparam int N  = 8;
  localparam int CW = tally_pkg::count_width(N);

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [N-1:0]  in_bits;
  logic          out_valid;
  logic [N:0]    tally_onehot;
  logic [CW-1:0] tally_count;

  int n_checks;
  int n_fail;

  onehot_tally #(.N(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_bits      (in_bits),
    .out_valid    (out_valid),
    .tally_onehot (tally_onehot),
    .tally_count  (tally_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pop(input logic [N-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  // Capture one word, then check the outputs one edge later.
  task automatic apply(input logic [N-1:0] v, input string req);
    logic [N:0] exp_oh;
    @(negedge clk);
    in_bits  = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_oh = (N+1)'(1) << pop(v);
    chk({req, " R1 onehot"}, 64'(tally_onehot), 64'(exp_oh));
    chk({req, " R4 count"}, 64'(tally_count), 64'(pop(v)));
    chk({req, " R5 valid high"}, 64'(out_valid), 64'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_bits = '0;
    repeat (3) @(negedge clk);
    chk("R7 valid", 64'(out_valid), 64'd0);
    chk("R7 onehot", 64'(tally_onehot), 64'd1);
    chk("R7 count", 64'(tally_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_extremes;
    apply('0, "R2 zeros");
    apply('1, "R3 ones");
    chk("R3 top line", 64'(tally_onehot[N]), 64'd1);
  endtask

  task automatic t_patterns;
    apply(8'h01, "R1 one bit low");
    apply(8'h80, "R1 one bit high");
    apply(8'h5A, "R1 four ones");
    apply(8'h7F, "R1 seven ones");
    apply(8'h3C, "R1 mid block");
  endtask

  task automatic t_position;
    logic [N:0] first;
    apply(8'h0F, "R9 low nibble");
    first = tally_onehot;
    apply(8'hF0, "R9 high nibble");
    chk("R9 same result", 64'(tally_onehot), 64'(first));
    apply(8'hA5, "R9 scattered");
    chk("R9 scattered same", 64'(tally_onehot), 64'(first));
  endtask

  task automatic t_hold;
    apply(8'h03, "R6 setup");
    @(negedge clk);
    chk("R5 valid drops", 64'(out_valid), 64'd0);
    in_bits = 8'hFF;
    @(negedge clk);
    chk("R6 onehot held", 64'(tally_onehot), 64'h4);
    chk("R6 count held", 64'(tally_count), 64'd2);
    chk("R5 valid stays low", 64'(out_valid), 64'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_bits = 8'h01; in_valid = 1'b1;
    @(negedge clk);
    chk("R5 b2b first valid", 64'(out_valid), 64'd1);
    chk("R1 b2b first", 64'(tally_onehot), 64'h2);
    in_bits = 8'h07;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 b2b second valid", 64'(out_valid), 64'd1);
    chk("R1 b2b second", 64'(tally_onehot), 64'h8);
    chk("R8 single line", 64'($countones(tally_onehot)), 64'd1);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    t_reset();
    t_extremes();
    t_patterns();
    t_position();
    t_hold();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule